// File: doc/BRIEF.md
# Two-Thread Shared Divider Arbiter

This block lets two hardware threads of a multithreaded core share one divide unit that is not pipelined. Each thread raises a request together with its dividend and divisor. The block accepts at most one operation at a time and keeps the unit marked busy for a fixed number of cycles. When that time has passed, it returns the quotient, the remainder and the number of the thread that owns the result.

A thread that is not accepted sees its stall output high and keeps its request and operands steady until it is granted. When both threads ask in the same cycle and the unit is free, a fairness policy picks the winner. The policy is selected by an input. In round-robin mode a priority pointer picks the winner, and after each such tie the pointer passes to the loser. In arrival-order mode the thread that began waiting first wins, and a tie in arrival falls back to the pointer. A new operation can start in the same cycle that the previous one reports completion, so the unit can run with no idle cycle between operations.

The arithmetic is a placeholder with the correct latency. The result is computed when the operation is accepted and is held until the completion pulse.

Top module: `div_share_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `done_o` and `grant_o` are all low. After reset the priority pointer favours thread 0.
- R2: When the unit is free and exactly one thread requests, that thread is granted in the same cycle. `grant_o` is never set for a thread that is not requesting, and at most one bit of `grant_o` is set.
- R3: While an operation is in flight and it is not its completion cycle, no grant is issued.
- R4: `done_o` pulses for one cycle exactly LAT cycles after the grant cycle. `done_tid_o` is 0 for thread 0 and 1 for thread 1, and names the thread that was granted.
- R5: In the `done_o` cycle, `quot_o` and `rem_o` equal the integer quotient and remainder of the operands that the granted thread presented in its grant cycle. A zero divisor gives a quotient of all ones and a remainder equal to the dividend.
- R6: If a thread requests in a completion cycle, it is granted in that same cycle.
- R7: `stall_o[i]` is high exactly when thread i requests and is not granted in that cycle.
- R8: With `policy_i` = 0 (round-robin), a tie on a free unit goes to the thread named by the priority pointer, and the pointer then moves to the losing thread. Grants without a tie leave the pointer unchanged.
- R9: With `policy_i` = 1 (arrival order), a tie on a free unit goes to the thread whose current request was raised in an earlier cycle. Requests raised in the same cycle are resolved by the round-robin pointer, which then moves as in R8.
- R10: A request that is held until it is granted is granted fewer than 2·LAT cycles after it was raised, in either policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | 0 = round-robin, 1 = arrival order |
| req_i | input | 2 | Per-thread divide request, bit i for thread i |
| dvd_i | input | 2·W | Dividends, thread i in bits [i·W +: W] |
| dvs_i | input | 2·W | Divisors, thread i in bits [i·W +: W] |
| grant_o | output | 2 | One-hot acceptance in the grant cycle |
| stall_o | output | 2 | Request present but not accepted |
| busy_o | output | 1 | An operation is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| done_tid_o | output | 1 | Owning thread of the completing result |
| quot_o | output | W | Quotient, valid with done_o |
| rem_o | output | W | Remainder, valid with done_o |

## Verification
A corrupted busy count shows up at the next completion: `done_o` arrives too early or too late. A new grant can then overlap the operation in flight, which is visible within LAT cycles of the fault. A stuck or mis-steered priority pointer or arrival history does not show at once. It shows at the next tie, where the wrong thread wins and the loser's stall lasts past its fairness bound. A wrong operand latch or owner register shows only at the completion pulse, as a wrong result or thread number LAT cycles after the grant.

// File: rtl/div_arb_pkg.sv
package div_arb_pkg;

  typedef enum logic {
    POL_RR   = 1'b0,
    POL_FIFO = 1'b1
  } arb_pol_e;

  // Winner of a tie in arrival-order mode.
  // wq: which threads were already waiting in the previous cycle.
  function automatic logic fifo_pick(input logic [1:0] wq,
                                     input logic       older,
                                     input logic       prio);
    logic w;
    case (wq)
      2'b01:   w = 1'b0;
      2'b10:   w = 1'b1;
      2'b11:   w = older;
      default: w = prio;
    endcase
    return w;
  endfunction

  // The pointer passes to the thread that lost the tie.
  function automatic logic prio_after_tie(input logic winner);
    return ~winner;
  endfunction

endpackage

// File: rtl/div_arb_timer.sv
module div_arb_timer #(
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/div_arb_pick.sv
module div_arb_pick
  import div_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       policy_i,
  input  logic       free_i,
  input  logic [1:0] req_i,
  output logic [1:0] grant_o,
  output logic       tie_o,
  output logic       prio_o
);
  logic       prio_q, older_q;
  logic [1:0] wait_q;
  logic       both_w, tie_win_w, win_w;
  logic [1:0] waiting_w;
  arb_pol_e   pol_w;

  assign pol_w     = arb_pol_e'(policy_i);
  assign both_w    = req_i[0] & req_i[1];
  assign tie_win_w = (pol_w == POL_FIFO) ? fifo_pick(wait_q, older_q, prio_q)
                                         : prio_q;
  assign win_w     = both_w ? tie_win_w : req_i[1];
  assign tie_o     = free_i & both_w;
  assign prio_o    = prio_q;

  for (genvar t = 0; t < 2; t++) begin : g_grant
    assign grant_o[t] = free_i & req_i[t] & (win_w == 1'(t));
  end

  assign waiting_w = req_i & ~grant_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= 1'b0;
      wait_q  <= 2'b00;
      older_q <= 1'b0;
    end else begin
      wait_q <= waiting_w;
      if (tie_o) prio_q <= prio_after_tie(win_w);
      if (waiting_w == 2'b11) begin
        case (wait_q)
          2'b01:   older_q <= 1'b0;
          2'b10:   older_q <= 1'b1;
          2'b00:   older_q <= prio_q;
          default: older_q <= older_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/div_arb_dp.sv
module div_arb_dp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  // Placeholder arithmetic: result formed at acceptance, held to completion.
  function automatic logic [2*W-1:0] div_calc(input logic [W-1:0] a,
                                              input logic [W-1:0] b);
    if (b == '0) return {{W{1'b1}}, a};
    return {a / b, a % b};
  endfunction

  logic [2*W-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (load_i) res_q <= div_calc(dvd_i, dvs_i);
  end

  assign quot_o = res_q[2*W-1:W];
  assign rem_o  = res_q[W-1:0];
endmodule

// File: rtl/div_share_arb.sv
module div_share_arb #(
  parameter int W   = 16,
  parameter int LAT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           policy_i,
  input  logic [1:0]     req_i,
  input  logic [2*W-1:0] dvd_i,
  input  logic [2*W-1:0] dvs_i,
  output logic [1:0]     grant_o,
  output logic [1:0]     stall_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           done_tid_o,
  output logic [W-1:0]   quot_o,
  output logic [W-1:0]   rem_o
);
  localparam int NT = 2;

  logic [W-1:0] dvd_a [NT];
  logic [W-1:0] dvs_a [NT];
  logic         free_w, start_w, conflict_w, prio_w, sel_w, owner_q;

  for (genvar t = 0; t < NT; t++) begin : g_ops
    assign dvd_a[t] = dvd_i[t*W +: W];
    assign dvs_a[t] = dvs_i[t*W +: W];
  end

  div_arb_timer #(.LAT(LAT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_w),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign free_w = ~busy_o | done_o;

  div_arb_pick u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .policy_i (policy_i),
    .free_i   (free_w),
    .req_i    (req_i),
    .grant_o  (grant_o),
    .tie_o    (conflict_w),
    .prio_o   (prio_w)
  );

  assign start_w = |grant_o;
  assign sel_w   = grant_o[1];
  assign stall_o = req_i & ~grant_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owner_q <= 1'b0;
    else if (start_w) owner_q <= sel_w;
  end
  assign done_tid_o = owner_q;

  div_arb_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_w),
    .dvd_i  (dvd_a[sel_w]),
    .dvs_i  (dvs_a[sel_w]),
    .quot_o (quot_o),
    .rem_o  (rem_o)
  );
endmodule

// File: rtl/div_share_arb_chk.sv
module div_share_arb_chk #(
  parameter int LAT = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       policy_i,
  input logic [1:0] req_i,
  input logic [1:0] grant_o,
  input logic [1:0] stall_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       done_tid_o,
  input logic       conflict_w,
  input logic       prio_w
);
  localparam int CW  = $clog2(LAT + 2);
  localparam int WCW = $clog2(2 * LAT + 2) + 1;
  localparam logic [WCW-1:0] WLIM = WCW'(2 * LAT);

  logic [CW-1:0]  mcnt_q;
  logic           mtid_q;
  logic [WCW-1:0] wcnt_q [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt_q <= '0;
      mtid_q <= 1'b0;
    end else if (grant_o != 2'b00) begin
      mcnt_q <= CW'(LAT);
      mtid_q <= grant_o[1];
    end else if (mcnt_q != '0) begin
      mcnt_q <= mcnt_q - 1'b1;
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_wait
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                wcnt_q[t] <= '0;
      else if (!stall_o[t])                      wcnt_q[t] <= '0;
      else if (wcnt_q[t] != {WCW{1'b1}})         wcnt_q[t] <= wcnt_q[t] + 1'b1;
    end
    // R10
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_q[t] < WLIM);
  end

  // R2
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && ((grant_o & ~req_i) == 2'b00));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |-> (grant_o == 2'b00));

  // R4
  done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == (mcnt_q == CW'(1)));

  // R4
  done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (done_tid_o == mtid_q));

  // R8
  rr_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_w && !policy_i) |-> grant_o[prio_w]);

  // R8
  ptr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_w |=> (prio_w != $past(grant_o[1])));
endmodule

bind div_share_arb div_share_arb_chk #(.LAT(LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .policy_i   (policy_i),
  .req_i      (req_i),
  .grant_o    (grant_o),
  .stall_o    (stall_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .done_tid_o (done_tid_o),
  .conflict_w (conflict_w),
  .prio_w     (prio_w)
);

// File: tb/div_share_arb_tb.sv
`timescale 1ns/100ps
module div_share_arb_tb;
  localparam int W   = 8;
  localparam int LAT = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           policy_i;
  logic [1:0]     req_i;
  logic [2*W-1:0] dvd_i, dvs_i;
  logic [1:0]     grant_o, stall_o;
  logic           busy_o, done_o, done_tid_o;
  logic [W-1:0]   quot_o, rem_o;

  always #2.5 clk = ~clk;

  div_share_arb #(.W(W), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .req_i(req_i),
    .dvd_i(dvd_i), .dvs_i(dvs_i), .grant_o(grant_o), .stall_o(stall_o),
    .busy_o(busy_o), .done_o(done_o), .done_tid_o(done_tid_o),
    .quot_o(quot_o), .rem_o(rem_o));

  int n_chk = 0, n_fail = 0;
  int cyc, kglob = 0, bprio;
  bit want [2];
  int arr [2], left [2], gap [2], jn [2];
  logic [W-1:0] ja [2], jb [2];
  bit infl; int gcyc, gtid; logic [W-1:0] eq, er;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic drive();
    for (int t = 0; t < 2; t++) begin
      req_i[t]        = want[t];
      dvd_i[t*W +: W] = ja[t];
      dvs_i[t*W +: W] = jb[t];
    end
  endtask

  task automatic new_job(input int t);
    ja[t] = W'((kglob * 53 + t * 101 + 17) % 256);
    jb[t] = (kglob % 5 == 3) ? '0 : W'((kglob * 7 + t * 3 + 1) % 23);
    kglob++;
  endtask

  // One clock: drive at the falling edge, sample just before the rising edge.
  task automatic step(input int gsel);
    bit expd, freex, both; int w;
    @(negedge clk);
    drive();
    #2;
    cyc++;
    chk(stall_o == (req_i & ~grant_o), "R7 stall", stall_o, req_i & ~grant_o);
    expd  = infl && (cyc - gcyc == LAT);
    freex = !infl || expd;
    if (expd || done_o) begin
      chk(done_o == expd, "R4 done timing", done_o, expd);
      if (expd) begin
        chk(done_tid_o == gtid[0], "R4 owner", done_tid_o, gtid);
        chk(quot_o == eq, "R5 quotient", quot_o, eq);
        chk(rem_o == er, "R5 remainder", rem_o, er);
        infl = 1'b0;
      end
    end
    if (grant_o != 2'b00) begin
      chk(freex, "R3 grant while busy", grant_o, 0);
      both = (req_i == 2'b11);
      if (both) begin
        if (policy_i) w = (arr[0] < arr[1]) ? 0 : (arr[1] < arr[0]) ? 1 : bprio;
        else          w = bprio;
        chk(grant_o == 2'(1 << w), policy_i ? "R9 arrival order" : "R8 pointer",
            grant_o, 1 << w);
        bprio = 1 - w;
      end else begin
        chk(grant_o == req_i, "R2 single grant", grant_o, req_i);
      end
      w = grant_o[1] ? 1 : 0;
      chk(cyc - arr[w] < 2 * LAT, "R10 wait bound", cyc - arr[w], 2 * LAT);
      infl = 1'b1; gcyc = cyc; gtid = w;
      if (jb[w] == '0) begin eq = '1; er = ja[w]; end
      else begin eq = ja[w] / jb[w]; er = ja[w] % jb[w]; end
      want[w] = 1'b0; left[w]--; jn[w]++;
      gap[w] = (jn[w] * gsel + w) % 4;
    end else if (freex && req_i != 2'b00) begin
      chk(1'b0, expd ? "R6 grant on done" : "R2 idle grant", 0, req_i);
    end
    for (int t = 0; t < 2; t++) begin
      if (want[t] && cyc - arr[t] >= 2 * LAT)
        chk(1'b0, "R10 starvation", cyc - arr[t], 2 * LAT);
      if (!want[t] && left[t] > 0) begin
        if (gap[t] > 0) gap[t]--;
        else begin want[t] = 1'b1; arr[t] = cyc + 1; new_job(t); end
      end
    end
  endtask

  task automatic run(input bit mode, input int off0, input int off1, input int gsel);
    int guard;
    policy_i = mode; rst_n = 1'b0;
    want = '{0, 0}; ja = '{0, 0}; jb = '{1, 1}; drive();
    repeat (2) @(posedge clk);
    #1;
    chk(!busy_o && !done_o && grant_o == 2'b00, "R1 reset state", {busy_o, done_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!busy_o && !done_o, "R1 after reset", {busy_o, done_o}, 0);
    cyc = 0; bprio = 0; infl = 0;
    left = '{3, 3}; jn = '{0, 0}; gap = '{off0, off1}; arr = '{0, 0};
    guard = 0;
    while ((left[0] + left[1] > 0 || want[0] || want[1] || infl) && guard < 400) begin
      step(gsel);
      guard++;
    end
    chk(guard < 400, "R10 run completes", guard, 400);
  endtask

  initial begin
    rst_n = 1'b0; policy_i = 1'b0; req_i = '0; dvd_i = '0; dvs_i = '0;
    // Sweep both policies (R8 round-robin, R9 arrival order) over start skews and gap patterns.
    for (int m = 0; m < 2; m++)
      for (int o0 = 0; o0 < 4; o0++)
        for (int o1 = 0; o1 < 4; o1++)
          for (int g = 0; g < 3; g++)
            run(m[0], o0, o1, g);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule